// File: doc/BRIEF.md
# Fixed-Priority Three-Way Stream Merge

This block merges three valid/ready message streams onto one valid/ready output stream. In every cycle it looks at the three input valids and picks one winner under a fixed ranking. It then drives the winner's message and a valid onto the output, and it hands the output's ready back to that winner alone. The block holds no state and no buffer, so the choice, the forwarded message and the returned ready all follow the inputs within the same cycle.

The ranking is input 1 first, then input 2, then input 0. A router stage uses this order to let traffic that is already moving through the fabric (inputs 1 and 2) go ahead of new traffic injected at the local terminal (input 0). The arbiter is not fair by design. A higher-ranked source that keeps its valid raised holds back every lower-ranked source for as long as it keeps it raised.

The message width is a parameter, 44 bits by default. The clock and the active-low reset serve only as the sampling reference for the built-in checks. They do not touch the datapath.

Top module: `prio_merge3`

## Requirements
- R1: `out_val` is high in exactly the cycles in which at least one bit of `in_val` is high.
- R2: Whenever `in_val[1]` is high, input 1 is the winner, whatever the other valids are.
- R3: When `in_val[2]` is high and `in_val[1]` is low, input 2 is the winner.
- R4: Input 0 wins only in cycles where `in_val[0]` is its sole raised valid.
- R5: While `out_val` is high, `out_msg` equals the full message (all `MSG_W` bits) of the winning input.
- R6: The winner's bit of `in_rdy` equals `out_rdy`, and every other bit of `in_rdy` is low, so at most one bit of `in_rdy` is ever high.
- R7: With no input valid, `out_val` is low, `in_rdy` is all zeros and `out_msg` is all zeros.
- R8: The block has no state: a change in `in_val`, `in_msg` or `out_rdy` shows up on the outputs within the same cycle, and the grant may move in any cycle.
- R9: Under random output back-pressure, every message a source presents (and holds until accepted) is delivered exactly once, in that source's order. A lower-ranked source stays blocked while a higher-ranked one keeps valid raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock for the built-in checks |
| rst_n | input | 1 | Synchronous active-low reset for the checks |
| in_msg | input | 3 x MSG_W | Message of each input stream, indexed by input number |
| in_val | input | 3 | Valid of each input stream |
| in_rdy | output | 3 | Ready returned to each input stream |
| out_msg | output | MSG_W | Forwarded message |
| out_val | output | 1 | Forwarded valid |
| out_rdy | input | 1 | Ready from the downstream consumer |

## Verification
The bench builds the block with the default 44-bit message width. Each message carries its source number in the top two bits and a per-source sequence count in the rest, so a wrong winner, a bit lost in the mux or a repeated delivery each produce a visible mismatch across the full width. Directed phases walk every valid pattern with the output both ready and stalled, and then hold input 1 valid to show that the others starve. A long random phase with sticky valids and random back-pressure drives the scoreboard, which checks ordering and exactly-once delivery.

// File: rtl/prio_merge3_pkg.sv
// Package: shared constants for the three-way fixed-priority merge.
// Assumes: exactly three inputs; the ranking table lists input numbers,
// highest rank first.
package prio_merge3_pkg;
    localparam int unsigned NUM_PORTS = 3;
    localparam int unsigned IDX_W     = $clog2(NUM_PORTS);
    // RANK_TO_PORT[k] = input number holding rank k (rank 0 wins first).
    localparam logic [NUM_PORTS-1:0][IDX_W-1:0] RANK_TO_PORT = {2'd0, 2'd2, 2'd1};
endpackage

// File: rtl/prio_merge3_pick.sv
// Module: prio_merge3_pick
// Turns a request vector into a one-hot grant by walking the ranks in the
// package's fixed order. A rank is granted only if no better rank requests.
// Assumes: the rank table is a permutation of the input numbers.
module prio_merge3_pick
    import prio_merge3_pkg::*;
(
    input  logic [NUM_PORTS-1:0] req,
    output logic [NUM_PORTS-1:0] grant,
    output logic                 any_req
);
    logic blocked;

    // Walk ranks best-first and grant the first requester met.
    always_comb begin
        blocked = 1'b0;
        grant   = '0;
        for (int k = 0; k < NUM_PORTS; k++) begin
            grant[RANK_TO_PORT[k]] = req[RANK_TO_PORT[k]] & ~blocked;
            blocked                = blocked | req[RANK_TO_PORT[k]];
        end
        any_req = blocked;
    end
endmodule

// File: rtl/prio_merge3_mux.sv
// Module: prio_merge3_mux
// AND-OR message selector driven by a one-hot grant. An all-zero grant
// yields an all-zero message.
// Assumes: the grant has at most one bit set.
module prio_merge3_mux
    import prio_merge3_pkg::*;
#(
    parameter int unsigned MSG_W = 44
) (
    input  logic [NUM_PORTS-1:0][MSG_W-1:0] in_msg,
    input  logic [NUM_PORTS-1:0]            grant,
    output logic [MSG_W-1:0]                out_msg
);
    // OR together each message masked by its grant bit.
    always_comb begin
        out_msg = '0;
        for (int i = 0; i < NUM_PORTS; i++) begin
            out_msg = out_msg | (in_msg[i] & {MSG_W{grant[i]}});
        end
    end
endmodule

// File: rtl/prio_merge3.sv
// Module: prio_merge3
// Stateless three-to-one valid/ready merge. Input 1 ranks first, input 2
// second, input 0 last. The output ready goes back only to the winner.
// Assumes: sources keep valid and message steady until accepted; clk and
// rst_n are used only by the assertions below.
module prio_merge3
    import prio_merge3_pkg::*;
#(
    parameter int unsigned MSG_W = 44
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_PORTS-1:0][MSG_W-1:0] in_msg,
    input  logic [NUM_PORTS-1:0]            in_val,
    output logic [NUM_PORTS-1:0]            in_rdy,
    output logic [MSG_W-1:0]                out_msg,
    output logic                            out_val,
    input  logic                            out_rdy
);
    logic [NUM_PORTS-1:0] grant;
    logic                 any_val;

    prio_merge3_pick u_pick (
        .req     (in_val),
        .grant   (grant),
        .any_req (any_val)
    );

    prio_merge3_mux #(.MSG_W(MSG_W)) u_mux (
        .in_msg  (in_msg),
        .grant   (grant),
        .out_msg (out_msg)
    );

    // Forward valid and return downstream ready to the winner only.
    always_comb begin
        out_val = any_val;
        in_rdy  = grant & {NUM_PORTS{out_rdy}};
    end

    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (|in_val) |-> out_val);
    assert_in1_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_val[1] && out_rdy) |-> (in_rdy == 3'b010));
    assert_in2_second_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_val[2] && !in_val[1] && out_rdy) |-> (in_rdy == 3'b100));
    assert_in0_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_rdy[0] |-> (!in_val[1] && !in_val[2]));
    assert_msg_matches_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_rdy[1] |-> (out_msg == in_msg[1]));
    assert_rdy_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(in_rdy));
    assert_rdy_needs_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|in_rdy) |-> out_rdy);
    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_val == '0) |-> (!out_val && in_rdy == '0 && out_msg == '0));
endmodule

// File: tb/prio_merge3_test.sv
`timescale 1ns/1ps
module prio_merge3_test;
    localparam int MSG_W = 44;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [2:0][MSG_W-1:0] in_msg = '0;
    logic [2:0]            in_val = '0;
    logic [2:0]            in_rdy;
    logic [MSG_W-1:0]      out_msg;
    logic                  out_val;
    logic                  out_rdy = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    logic [MSG_W-1:0] sb_q[$];
    logic [2:0] pend = '0;
    int seq[3] = '{0, 0, 0};
    int got[3] = '{0, 0, 0};

    always #2.5 clk = ~clk;

    prio_merge3 #(.MSG_W(MSG_W)) uut (
        .clk(clk), .rst_n(rst_n), .in_msg(in_msg), .in_val(in_val),
        .in_rdy(in_rdy), .out_msg(out_msg), .out_val(out_val), .out_rdy(out_rdy)
    );

    function automatic logic [MSG_W-1:0] mk(int src, int s);
        return {2'(src), (MSG_W-2)'(s)};
    endfunction

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one cycle: raise new requests, hold pending ones, check outputs.
    task automatic cycle(input logic [2:0] want, input logic rdy);
        int w;
        string tag;
        logic [2:0] exp_rdy;
        @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            if (!pend[k] && want[k]) pend[k] = 1'b1;
            in_msg[k] = mk(k, seq[k]);
        end
        in_val  = pend;
        out_rdy = rdy;
        #1;
        w = pend[1] ? 1 : pend[2] ? 2 : pend[0] ? 0 : -1;
        tag = (w == 1) ? "R2" : (w == 2) ? "R3" : (w == 0) ? "R4" : "R7";
        exp_rdy = (w >= 0 && rdy) ? 3'(1 << w) : 3'b000;
        check(out_val == (w >= 0), "R1/R8 out_val", 64'(out_val), 64'(w >= 0));
        check(in_rdy == exp_rdy, {tag, "/R6 in_rdy"}, 64'(in_rdy), 64'(exp_rdy));
        if (w >= 0) begin
            check(out_msg == mk(w, seq[w]), {tag, "/R5 out_msg"}, 64'(out_msg), 64'(mk(w, seq[w])));
            if (rdy) begin
                sb_q.push_back(mk(w, seq[w]));
                pend[w] = 1'b0;
                seq[w]++;
            end
        end else begin
            check(out_msg == '0, "R7 out_msg", 64'(out_msg), 64'd0);
        end
    endtask

    // Monitor: pop expected items on every accepted transfer (R9).
    always @(posedge clk) begin
        if (rst_n && out_val && out_rdy) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R9 unexpected delivery", 64'(out_msg), 64'd0);
            end else begin
                logic [MSG_W-1:0] e;
                e = sb_q.pop_front();
                check(out_msg == e, "R9 order", 64'(out_msg), 64'(e));
                got[int'(out_msg[MSG_W-1 -: 2])]++;
            end
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        check(out_val == 1'b0, "R7 reset out_val", 64'(out_val), 64'd0);
        check(in_rdy == 3'b000, "R7 reset in_rdy", 64'(in_rdy), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        // Every valid pattern with the output stalled, then ready.
        for (int p = 0; p < 8; p++) begin
            cycle(3'(p), 1'b0);
            cycle(3'b000, 1'b1);
            cycle(3'b000, 1'b1);
            cycle(3'b000, 1'b1);
        end
        // R9 starvation: input 1 stays valid; 0 and 2 must wait.
        for (int c = 0; c < 20; c++) begin
            cycle(3'b111, 1'b1);
            check(in_rdy[0] == 1'b0 && in_rdy[2] == 1'b0, "R9 starve",
                  64'(in_rdy), 64'b010);
        end
        for (int c = 0; c < 6; c++) cycle(3'b000, 1'b1);
        // Random traffic with sticky valids and random back-pressure.
        for (int c = 0; c < 2000; c++) begin
            logic [2:0] wv;
            for (int k = 0; k < 3; k++) wv[k] = ($urandom_range(0, 9) < 6);
            cycle(wv, $urandom_range(0, 9) < 7);
        end
        for (int c = 0; c < 10; c++) cycle(3'b000, 1'b1);
        @(negedge clk);
        in_val = '0;
        repeat (2) @(posedge clk);
        #1;
        check(sb_q.size() == 0, "R9 queue drained", 64'(sb_q.size()), 64'd0);
        for (int k = 0; k < 3; k++)
            check(got[k] == seq[k], "R9 exactly once", 64'(got[k]), 64'(seq[k]));
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            check(1'b0, "watchdog", 64'd0, 64'd1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule